// File: doc/BRIEF.md
# Mode-Banked Register File

A register file for a small 16-bit core. Each register is picked by a 3-bit specifier. Specifiers 0 to 3 always name four general registers. What specifiers 4 to 7 name depends on the privilege bit kept in the block's own status register. In user mode they name four more general registers. In kernel mode they name the system bank: the instruction pointer, the stack pointer, the return register and the status register.

The block has two combinational read ports and one synchronous write port. Each port has its own per-access override input, which forces specifiers 4 to 7 onto the system bank whatever the mode. Stack-style accesses use this so that user code can save and restore the return register.

The write port supports four byte-lane modes:
- a whole-word write;
- a low-byte immediate that clears the upper byte;
- a high-byte immediate that keeps the lower byte;
- a byte load that zero-fills the upper byte.

The instruction pointer is 24 bits wide. Its full value is always visible on a dedicated port.

Top module: `banked_regfile`

## Requirements
- R1: Specifiers 0 to 3 select general registers a, b, c and d. This holds in both modes, with or without the override, on both read ports and on the write port.
- R2: With the mode bit clear (user mode), specifiers 4 to 7 without override select general registers e, f, g and h.
- R3: With the mode bit set (kernel mode), specifiers 4, 5, 6 and 7 select the instruction pointer, stack pointer, return register and status register.
- R4: An override input set with a specifier of 4 to 7 selects the system bank even in user mode. Each port has its own override.
- R5: The mode bit is bit 12 of the status register (1 = kernel). A write that changes that bit changes the bank decode from the next cycle on.
- R6: Write mode 0 stores the whole word. A write to the instruction pointer takes all 24 bits of the write data; other registers take bits 15:0.
- R7: Write mode 1 (low-byte immediate) stores data bits 7:0 in bits 7:0 and clears bits 15:8. Instruction pointer bits 23:16 are kept.
- R8: Write mode 2 (high-byte immediate) stores data bits 7:0 in bits 15:8 and keeps bits 7:0. Instruction pointer bits 23:16 are kept.
- R9: Write mode 3 (byte load) stores data bits 7:0 in bits 7:0 and zero-fills bits 15:8. Instruction pointer bits 23:16 are kept.
- R10: A 16-bit read of the instruction pointer returns its low 16 bits. The ip output always shows all 24 bits.
- R11: After reset every register is zero except status, which reads 0x1000 (kernel mode).
- R12: A read of the register being written in the same cycle returns the old value. The new value appears after the clock edge.
- R13: With the write enable low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdSelA | input | 3 | Read port A specifier |
| rdSysA | input | 1 | Read port A system-bank override |
| rdDataA | output | 16 | Read port A data |
| rdSelB | input | 3 | Read port B specifier |
| rdSysB | input | 1 | Read port B system-bank override |
| rdDataB | output | 16 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrSel | input | 3 | Write specifier |
| wrSys | input | 1 | Write system-bank override |
| wrMode | input | 2 | Byte-lane write mode (0 word, 1 low imm, 2 high imm, 3 byte load) |
| wrData | input | 24 | Write data (24 bits used only by the instruction pointer) |
| ipOut | output | 24 | Full instruction pointer |
| kernelMode | output | 1 | Current mode bit from status |

## Verification
A wrong bank decode shows at the read ports at once, in the same cycle as the specifier. So every specifier is read in both modes and with both override settings after each write. A corrupted byte lane or a stray write shows at the next read of the affected register, one clock after the write. A mode bit that fails to follow status shows on the kernel-mode output and in the decode on the very next cycle.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int DATA_W   = 16;
  localparam int IP_W     = 24;
  localparam int BYTE_W   = 8;
  localparam int SPEC_W   = 3;
  localparam int NGEN     = 1 << SPEC_W;
  localparam int NSYS     = 1 << (SPEC_W - 1);
  localparam int SYS_W    = SPEC_W - 1;
  localparam int MODE_BIT = 12;
  localparam int NPORT    = 2;

  typedef enum logic [1:0] {
    WR_WORD    = 2'd0,
    WR_LO_IMM  = 2'd1,
    WR_HI_IMM  = 2'd2,
    WR_LO_LOAD = 2'd3
  } wr_mode_e;

  typedef struct packed {
    logic [NGEN-1:0]              genWe;
    logic [NSYS-1:0]              sysWe;
    wr_mode_e                     wrMode;
    logic [NPORT-1:0]             rdSys;
    logic [NPORT-1:0][SPEC_W-1:0] rdIdx;
  } strobe_t;

  function automatic logic [IP_W-1:0] mergeWrite(
    input logic [IP_W-1:0] oldVal,
    input logic [IP_W-1:0] newVal,
    input wr_mode_e        mode
  );
    logic [IP_W-1:0] res;
    case (mode)
      WR_WORD:   res = newVal;
      WR_HI_IMM: res = {oldVal[IP_W-1:DATA_W], newVal[BYTE_W-1:0], oldVal[BYTE_W-1:0]};
      default:   res = {oldVal[IP_W-1:DATA_W], {BYTE_W{1'b0}}, newVal[BYTE_W-1:0]};
    endcase
    return res;
  endfunction
endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              kernelMode,
  input  logic [SPEC_W-1:0] rdSelA,
  input  logic              rdSysA,
  input  logic [SPEC_W-1:0] rdSelB,
  input  logic              rdSysB,
  input  logic              wrEn,
  input  logic [SPEC_W-1:0] wrSel,
  input  logic              wrSys,
  input  logic [1:0]        wrMode,
  output strobe_t           st
);
  logic wrBank;

  always_comb begin
    wrBank   = wrSel[SPEC_W-1] & (kernelMode | wrSys);
    st       = '0;
    st.wrMode = wr_mode_e'(wrMode);
    if (wrEn) begin
      if (wrBank) st.sysWe[wrSel[SYS_W-1:0]] = 1'b1;
      else        st.genWe[wrSel] = 1'b1;
    end
    st.rdSys[0] = rdSelA[SPEC_W-1] & (kernelMode | rdSysA);
    st.rdIdx[0] = rdSelA;
    st.rdSys[1] = rdSelB[SPEC_W-1] & (kernelMode | rdSysB);
    st.rdIdx[1] = rdSelB;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.genWe, st.sysWe})) else $error("multiple write targets"); // R13
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ($countones({st.genWe, st.sysWe}) == 0)) else $error("strobe without enable"); // R13
  AST_LOW_SPEC_GENERAL: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel[SPEC_W-1]) |-> (st.sysWe == '0)) else $error("low specifier hit system bank"); // R1
  AST_OVERRIDE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdSysA && rdSelA[SPEC_W-1]) |-> st.rdSys[0]) else $error("override ignored"); // R4
endmodule

// File: rtl/bankreg_dpath.sv
module bankreg_dpath
  import bankreg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       st,
  input  logic [IP_W-1:0]               wrData,
  output logic [NPORT-1:0][DATA_W-1:0]  rdData,
  output logic [IP_W-1:0]               ipOut,
  output logic                          kernelMode
);
  localparam int ST_IDX = NSYS - 1;
  localparam logic [DATA_W-1:0] ST_RESET = DATA_W'(1) << MODE_BIT;

  logic [DATA_W-1:0] genQ [NGEN];
  logic [DATA_W-1:0] sysQ [NSYS-1:1];
  logic [IP_W-1:0]   ipQ;

  genvar i;
  generate
    for (i = 0; i < NGEN; i++) begin : g_gen
      always_ff @(posedge clk) begin
        if (!rstN)            genQ[i] <= '0;
        else if (st.genWe[i]) genQ[i] <= DATA_W'(mergeWrite(IP_W'(genQ[i]), wrData, st.wrMode));
      end

      AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
        (st.genWe[i] && st.wrMode == WR_HI_IMM) |=> (genQ[i][BYTE_W-1:0] == $past(genQ[i][BYTE_W-1:0])))
        else $error("high write touched low byte"); // R8
      AST_LO_CLEARS_HI: assert property (@(posedge clk) disable iff (!rstN)
        (st.genWe[i] && (st.wrMode == WR_LO_IMM || st.wrMode == WR_LO_LOAD)) |=> (genQ[i][DATA_W-1:BYTE_W] == '0))
        else $error("low write left upper byte"); // R7
    end

    for (i = 1; i < NSYS; i++) begin : g_sys
      always_ff @(posedge clk) begin
        if (!rstN)            sysQ[i] <= (i == ST_IDX) ? ST_RESET : '0;
        else if (st.sysWe[i]) sysQ[i] <= DATA_W'(mergeWrite(IP_W'(sysQ[i]), wrData, st.wrMode));
      end
    end

    for (i = 0; i < NPORT; i++) begin : g_rd
      always_comb begin
        if (!st.rdSys[i])                        rdData[i] = genQ[st.rdIdx[i]];
        else if (st.rdIdx[i][SYS_W-1:0] == '0)   rdData[i] = ipQ[DATA_W-1:0];
        else                                     rdData[i] = sysQ[st.rdIdx[i][SYS_W-1:0]];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)          ipQ <= '0;
    else if (st.sysWe[0]) ipQ <= mergeWrite(ipQ, wrData, st.wrMode);
  end

  assign ipOut      = ipQ;
  assign kernelMode = sysQ[ST_IDX][MODE_BIT];

  AST_MODE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> kernelMode) else $error("not kernel after reset"); // R11
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !st.sysWe[ST_IDX] |=> $stable(kernelMode)) else $error("mode moved without status write"); // R5
  AST_IP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !st.sysWe[0] |=> $stable(ipQ)) else $error("ip moved without write"); // R13
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SPEC_W-1:0] rdSelA,
  input  logic              rdSysA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [SPEC_W-1:0] rdSelB,
  input  logic              rdSysB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [SPEC_W-1:0] wrSel,
  input  logic              wrSys,
  input  logic [1:0]        wrMode,
  input  logic [IP_W-1:0]   wrData,
  output logic [IP_W-1:0]   ipOut,
  output logic              kernelMode
);
  strobe_t st;
  logic [NPORT-1:0][DATA_W-1:0] rdData;

  bankreg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .kernelMode(kernelMode),
    .rdSelA(rdSelA), .rdSysA(rdSysA), .rdSelB(rdSelB), .rdSysB(rdSysB),
    .wrEn(wrEn), .wrSel(wrSel), .wrSys(wrSys), .wrMode(wrMode), .st(st)
  );

  bankreg_dpath u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .rdData(rdData), .ipOut(ipOut), .kernelMode(kernelMode)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  rdSelA = '0, rdSelB = '0, wrSel = '0;
  logic        rdSysA = 1'b0, rdSysB = 1'b0, wrSys = 1'b0, wrEn = 1'b0;
  logic [1:0]  wrMode = '0;
  logic [23:0] wrData = '0;
  logic [15:0] rdDataA, rdDataB;
  logic [23:0] ipOut;
  logic        kernelMode;

  int nChk = 0;
  int nBad = 0;

  logic [15:0] mGen [8];
  logic [15:0] mSys [4];
  logic [23:0] mIp;

  banked_regfile u_dut (
    .clk(clk), .rstN(rstN),
    .rdSelA(rdSelA), .rdSysA(rdSysA), .rdDataA(rdDataA),
    .rdSelB(rdSelB), .rdSysB(rdSysB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrSel(wrSel), .wrSys(wrSys), .wrMode(wrMode), .wrData(wrData),
    .ipOut(ipOut), .kernelMode(kernelMode)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [2:0] sel, input logic ovr);
    logic sys;
    sys = sel[2] & (mSys[3][12] | ovr);
    if (!sys) return mGen[sel];
    if (sel[1:0] == 2'd0) return mIp[15:0];
    return mSys[sel[1:0]];
  endfunction

  function automatic logic [23:0] bmerge(input logic [23:0] o, input logic [23:0] d,
                                         input logic [1:0] md, input logic isIp);
    logic [23:0] n;
    case (md)
      2'd0: n = d;
      2'd2: n = {o[23:16], d[7:0], o[7:0]};
      default: n = {o[23:16], 8'h00, d[7:0]};
    endcase
    if (!isIp) n[23:16] = 8'h00;
    return n;
  endfunction

  task automatic modelWrite(input logic [2:0] sel, input logic ovr, input logic [1:0] md,
                            input logic [23:0] d);
    logic sys;
    logic [23:0] t;
    sys = sel[2] & (mSys[3][12] | ovr);
    if (!sys) begin
      t = bmerge({8'h00, mGen[sel]}, d, md, 1'b0);
      mGen[sel] = t[15:0];
    end else if (sel[1:0] == 2'd0) begin
      mIp = bmerge(mIp, d, md, 1'b1);
    end else begin
      t = bmerge({8'h00, mSys[sel[1:0]]}, d, md, 1'b0);
      mSys[sel[1:0]] = t[15:0];
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic ovr, input logic [1:0] md, input logic [23:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrSys = ovr; wrMode = md; wrData = d;
    @(posedge clk);
    #1;
    modelWrite(sel, ovr, md, d);
    wrEn = 1'b0;
  endtask

  task automatic chkAll(input string tag);
    for (int s = 0; s < 8; s++) begin
      for (int o = 0; o < 2; o++) begin
        rdSelA = 3'(s); rdSysA = o[0];
        rdSelB = 3'(7 - s); rdSysB = ~o[0];
        #1;
        check($sformatf("%s portA sel=%0d ovr=%0d", tag, s, o), {8'h00, rdDataA}, {8'h00, expRead(3'(s), o[0])});
        check($sformatf("%s portB sel=%0d ovr=%0d", tag, 7 - s, 1 - o), {8'h00, rdDataB},
              {8'h00, expRead(3'(7 - s), ~o[0])});
      end
    end
    check({tag, " R10 ipOut"}, ipOut, mIp);
    check({tag, " R5 mode"}, {23'h0, kernelMode}, {23'h0, mSys[3][12]});
  endtask

  initial begin
    #(PERIOD * 100000);
    nBad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [23:0] d;
    for (int k = 0; k < 8; k++) mGen[k] = '0;
    for (int k = 0; k < 4; k++) mSys[k] = '0;
    mSys[3] = 16'h1000;
    mIp = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: reset state, kernel mode, status = 0x1000
    check("R11 kernel after reset", {23'h0, kernelMode}, 24'h1);
    chkAll("R11");

    // R3, R6: kernel-mode whole-word writes to every specifier
    for (int s = 0; s < 8; s++) begin
      d = 24'h5A0000 ^ (24'(s) * 24'h1357) ^ 24'h00A0C3;
      if (s == 7) d[12] = 1'b1;
      wr(3'(s), 1'b0, 2'd0, d);
    end
    chkAll("R3 R6");
    check("R10 ip high bits kept", {16'h0, ipOut[23:16]}, {16'h0, mIp[23:16]});

    // R5: clear mode bit via status -> user mode next cycle
    wr(3'd7, 1'b0, 2'd0, 24'h000A05);
    check("R5 user after status write", {23'h0, kernelMode}, 24'h0);
    chkAll("R5");

    // R2: user writes to 4..7 land in e..h
    for (int s = 4; s < 8; s++) wr(3'(s), 1'b0, 2'd0, 24'h00E000 + 24'(s * 24'h0111));
    chkAll("R2");
    chkAll("R1");

    // R4: override writes reach the system bank in user mode
    wr(3'd5, 1'b1, 2'd0, 24'h00C0DE);
    wr(3'd4, 1'b1, 2'd0, 24'hABCDEF);
    check("R10 ipOut full", ipOut, 24'hABCDEF);
    chkAll("R4");

    // R7, R8, R9: byte-lane sweep on every register in both banks
    for (int s = 0; s < 8; s++) begin
      for (int o = 0; o < 2; o++) begin
        for (int md = 1; md < 4; md++) begin
          wr(3'(s), o[0], 2'd0, (s == 7 && o == 1) ? 24'hFFEFFF : 24'hFFFFFF);
          d = 24'h123400 | 24'((s * 37 + md * 11 + o * 5) & 8'hFF);
          if (s == 7 && o == 1) d[4] = 1'b0;
          wr(3'(s), o[0], 2'(md), d);
          chkAll(md == 1 ? "R7" : (md == 2 ? "R8" : "R9"));
        end
      end
    end

    // R12: same-cycle read of the written register returns the old value
    @(negedge clk);
    rdSelA = 3'd2; rdSysA = 1'b0;
    wrEn = 1'b1; wrSel = 3'd2; wrSys = 1'b0; wrMode = 2'd0; wrData = 24'h00BEEF;
    #1;
    check("R12 old value during write", {8'h0, rdDataA}, {8'h0, mGen[2]});
    @(posedge clk);
    #1;
    modelWrite(3'd2, 1'b0, 2'd0, 24'h00BEEF);
    wrEn = 1'b0;
    check("R12 new value after edge", {8'h0, rdDataA}, 24'h00BEEF);

    // R13: enable low, other write inputs busy
    @(negedge clk);
    wrEn = 1'b0; wrSel = 3'd4; wrSys = 1'b1; wrMode = 2'd0; wrData = 24'h777777;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wrSel = 3'd1; wrSys = 1'b0; wrData = 24'h000BAD;
    repeat (2) @(posedge clk);
    #1;
    chkAll("R13");

    // R5: back to kernel through an override write of status
    wr(3'd7, 1'b1, 2'd0, 24'h001F00);
    check("R5 kernel after override status write", {23'h0, kernelMode}, 24'h1);
    chkAll("R3 R5");

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule